// File: doc/BRIEF.md
# Privilege-Aware Interrupt Selector

This block decides, once per clock, whether a processor hart has a local interrupt it must take, and if so which one. It combines the pending vector with the per-interrupt enable vector to form candidates. Each candidate is then gated by a global enable that depends on two things. The first is whether the interrupt has been handed down to supervisor level by the delegation mask. The second is how the current privilege level compares with that target level.

An interrupt whose target level is above the current privilege is always enabled. An interrupt whose target level equals the current privilege follows that level's status bit. An interrupt whose target level is below the current privilege is never enabled. The surviving set goes through a lowest-index-first priority search. The result is a valid flag and a cause number, both registered, which the trap logic of the core uses on the following cycle.

Privilege is encoded U=0, S=1, M=3. The reserved code 2 is handled exactly like M.

Top module: `intr_select`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both `irq_pending` and `irq_enable`. Bit i is interrupt number i. With no bit set in both vectors, `take_valid` is 0.
- R2: A non-delegated candidate (its `irq_deleg` bit is 0) is taken at privilege U (0) or S (1) regardless of `m_gie`.
- R3: At privilege M (3), a non-delegated candidate is taken only when `m_gie` is 1.
- R4: A delegated candidate (its `irq_deleg` bit is 1) is taken at privilege U (0) regardless of `s_gie`.
- R5: At privilege S (1), a delegated candidate is taken only when `s_gie` is 1.
- R6: At privilege M, a delegated candidate is never taken, whatever `s_gie` and `m_gie` are.
- R7: When several interrupts survive gating, `take_cause` is the lowest surviving bit index, as an unsigned binary number.
- R8: When nothing survives gating, `take_valid` is 0 and `take_cause` is 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, both outputs are cleared to 0.
- R10: Privilege code 2 behaves exactly like M for both non-delegated and delegated interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_pending | input | NUM_IRQ | Pending interrupt bits |
| irq_enable | input | NUM_IRQ | Per-interrupt enable bits |
| irq_deleg | input | NUM_IRQ | 1 = interrupt delegated to supervisor level |
| priv_lvl | input | 2 | Current privilege: 0 U, 1 S, 3 M, 2 treated as M |
| m_gie | input | 1 | Machine-level global interrupt enable |
| s_gie | input | 1 | Supervisor-level global interrupt enable |
| take_valid | output | 1 | An interrupt must be taken |
| take_cause | output | CAUSE_W | Index of the selected interrupt |

## Verification
The bench builds the block with the default width of 32 interrupts, which gives a 5-bit cause. At that width both ends of the priority search can be reached, cause 0 and cause 31, as can the full-vector patterns where every lower bit is masked off by delegation or enable. Directed vectors go through each privilege code against each global-enable combination, with delegated and non-delegated candidates. A long stream of pseudo-random vectors follows and exercises mixed delegation masks with several survivors competing for the lowest index.

// File: rtl/intr_sel_pkg.sv
package intr_sel_pkg;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_SUPV = 2'd1,
    LVL_RSVD = 2'd2,
    LVL_MACH = 2'd3
  } priv_lvl_e;

  // Effective privilege used for enable decisions: reserved folds into machine.
  function automatic priv_lvl_e fold_priv(input logic [1:0] code);
    priv_lvl_e lvl;
    lvl = priv_lvl_e'(code);
    if (lvl == LVL_RSVD) lvl = LVL_MACH;
    return lvl;
  endfunction

endpackage

// File: rtl/intr_level_enable.sv
module intr_level_enable
  import intr_sel_pkg::*;
(
  input  logic [1:0] priv_lvl,
  input  logic       m_gie,
  input  logic       s_gie,
  output logic       m_lvl_en,
  output logic       s_lvl_en
);

  priv_lvl_e eff;

  always_comb begin
    eff = fold_priv(priv_lvl);
    // Machine target: open below machine, gated by m_gie at machine.
    m_lvl_en = (eff != LVL_MACH) || m_gie;
    // Supervisor target: open in user, gated by s_gie in supervisor, shut above.
    unique case (eff)
      LVL_USER: s_lvl_en = 1'b1;
      LVL_SUPV: s_lvl_en = s_gie;
      default:  s_lvl_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/intr_mask_merge.sv
module intr_mask_merge #(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  input  logic               m_lvl_en,
  input  logic               s_lvl_en,
  output logic [NUM_IRQ-1:0] survivors
);

  logic [NUM_IRQ-1:0] cand;

  assign cand = irq_pending & irq_enable;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    assign survivors[i] = cand[i] & (irq_deleg[i] ? s_lvl_en : m_lvl_en);
  end

endmodule

// File: rtl/intr_lsb_find.sv
module intr_lsb_find #(
  parameter  int WIDTH = 32,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] index
);

  always_comb begin
    found = |vec;
    index = '0;
    // Walk from the top down so the last hit left standing is the lowest bit.
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) index = IDX_W'(i);
    end
  end

endmodule

// File: rtl/intr_select.sv
module intr_select #(
  parameter  int NUM_IRQ = 32,
  localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  input  logic [1:0]         priv_lvl,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic               take_valid,
  output logic [CAUSE_W-1:0] take_cause
);

  logic               m_lvl_en;
  logic               s_lvl_en;
  logic [NUM_IRQ-1:0] survivors;
  logic               hit;
  logic [CAUSE_W-1:0] hit_idx;

  intr_level_enable u_lvl (
    .priv_lvl (priv_lvl),
    .m_gie    (m_gie),
    .s_gie    (s_gie),
    .m_lvl_en (m_lvl_en),
    .s_lvl_en (s_lvl_en)
  );

  intr_mask_merge #(.NUM_IRQ(NUM_IRQ)) u_merge (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .irq_deleg   (irq_deleg),
    .m_lvl_en    (m_lvl_en),
    .s_lvl_en    (s_lvl_en),
    .survivors   (survivors)
  );

  intr_lsb_find #(.WIDTH(NUM_IRQ)) u_find (
    .vec   (survivors),
    .found (hit),
    .index (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_valid <= 1'b0;
      take_cause <= '0;
    end else begin
      take_valid <= hit;
      take_cause <= hit ? hit_idx : '0;
    end
  end

endmodule

// File: rtl/intr_select_chk.sv
module intr_select_chk #(
  parameter  int NUM_IRQ = 32,
  localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] irq_pending,
  input logic [NUM_IRQ-1:0] irq_enable,
  input logic [NUM_IRQ-1:0] irq_deleg,
  input logic [1:0]         priv_lvl,
  input logic               m_gie,
  input logic               s_gie,
  input logic               take_valid,
  input logic [CAUSE_W-1:0] take_cause
);

  logic primed;
  always_ff @(posedge clk) primed <= !rst;

  // R9: reset clears the flag
  p_reset_clear_r9: assert property (@(posedge clk) rst |=> !take_valid && take_cause == '0);

  // R8: idle output carries cause zero
  p_idle_cause_zero_r8: assert property (@(posedge clk) disable iff (rst)
    primed && !take_valid |-> take_cause == '0);

  // R1: the chosen bit was pending and enabled
  p_chosen_is_candidate_r1: assert property (@(posedge clk) disable iff (rst)
    primed && take_valid |-> (($past(irq_pending & irq_enable) >> take_cause) & 1) != 0);

  // R6 / R10: at machine or reserved code the chosen bit is never delegated
  p_no_deleg_at_m_r6: assert property (@(posedge clk) disable iff (rst)
    primed && take_valid && $past(priv_lvl[1]) |-> (($past(irq_deleg) >> take_cause) & 1) == 0);

  // R3: machine level with m_gie low takes nothing
  p_m_gate_r3: assert property (@(posedge clk) disable iff (rst)
    primed && $past(priv_lvl[1] && !m_gie) |-> !take_valid);

  // R4: user level takes any candidate
  p_user_takes_r4: assert property (@(posedge clk) disable iff (rst)
    primed && $past(priv_lvl == 2'd0 && (irq_pending & irq_enable) != '0) |-> take_valid);

  // R5: supervisor level with s_gie low ignores delegated candidates
  p_s_gate_r5: assert property (@(posedge clk) disable iff (rst)
    primed && $past(priv_lvl == 2'd1 && !s_gie &&
                    (irq_pending & irq_enable & ~irq_deleg) == '0) |-> !take_valid);

endmodule

bind intr_select intr_select_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_pending (irq_pending),
  .irq_enable  (irq_enable),
  .irq_deleg   (irq_deleg),
  .priv_lvl    (priv_lvl),
  .m_gie       (m_gie),
  .s_gie       (s_gie),
  .take_valid  (take_valid),
  .take_cause  (take_cause)
);

// File: tb/intr_select_tb.sv
module intr_select_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pend = '0, en = '0, dlg = '0;
  logic [1:0]    pr = 2'd0;
  logic          mg = 1'b0, sg = 1'b0;
  logic          t_valid;
  logic [4:0]    t_cause;

  int vectors = 0;
  int miss = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_select #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst(rst), .irq_pending(pend), .irq_enable(en), .irq_deleg(dlg),
    .priv_lvl(pr), .m_gie(mg), .s_gie(sg), .take_valid(t_valid), .take_cause(t_cause)
  );

  // Behavioural reference: walk the bits, decide each one by the rules.
  task automatic ref_model(input logic [N-1:0] p, e, d, input logic [1:0] lv,
                           input logic m, s, output logic v, output int c);
    int level;
    bit ok;
    level = (lv == 2'd2) ? 3 : int'(lv);
    v = 1'b0;
    c = 0;
    for (int i = 0; i < N; i++) begin
      ok = 0;
      if (p[i] && e[i]) begin
        if (d[i]) begin
          if (level == 0) ok = 1;
          else if (level == 1) ok = s;
        end else begin
          if (level < 3) ok = 1;
          else ok = m;
        end
      end
      if (ok && !v) begin
        v = 1'b1;
        c = i;
      end
    end
  endtask

  task automatic compare(input string tag, input logic ev, input int ec);
    vectors++;
    if (t_valid !== ev || int'(t_cause) != ec) begin
      miss++;
      $display("FAIL %s: valid=%0b cause=%0d expected valid=%0b cause=%0d",
               tag, t_valid, t_cause, ev, ec);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge (one register).
  task automatic apply(input string tag, input logic [N-1:0] p, e, d,
                       input logic [1:0] lv, input logic m, s);
    logic ev;
    int ec;
    pend = p; en = e; dlg = d; pr = lv; mg = m; sg = s;
    ref_model(p, e, d, lv, m, s, ev, ec);
    @(posedge clk);
    @(negedge clk);
    compare(tag, ev, ec);
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    miss++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    logic [N-1:0] rp, re, rd;
    // R9: reset state, with inputs that would otherwise select something
    pend = 32'h1; en = 32'h1; pr = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R9 reset", 1'b0, 0);
    rst = 1'b0;

    apply("R2 user nondeleg",     32'h8,   32'h8,   32'h0, 2'd0, 1'b0, 1'b0);
    apply("R2 super nondeleg",    32'h80,  32'h80,  32'h0, 2'd1, 1'b0, 1'b0);
    apply("R3 machine mgie on",   32'h800, 32'h800, 32'h0, 2'd3, 1'b1, 1'b0);
    apply("R3 machine mgie off",  32'h800, 32'h800, 32'h0, 2'd3, 1'b0, 1'b1);
    apply("R4 user deleg",        32'h20,  32'h20,  32'h20, 2'd0, 1'b0, 1'b0);
    apply("R5 super deleg sgie off", 32'h20, 32'h20, 32'h20, 2'd1, 1'b1, 1'b0);
    apply("R5 super deleg sgie on",  32'h20, 32'h20, 32'h20, 2'd1, 1'b0, 1'b1);
    apply("R6 machine deleg only",   32'h2, 32'h2, 32'h2, 2'd3, 1'b1, 1'b1);
    apply("R6 machine mixed",        32'h202, 32'h202, 32'h2, 2'd3, 1'b1, 1'b1);
    apply("R10 code2 mgie off",      32'h8, 32'h8, 32'h0, 2'd2, 1'b0, 1'b1);
    apply("R10 code2 mgie on",       32'h8, 32'h8, 32'h0, 2'd2, 1'b1, 1'b0);
    apply("R10 code2 deleg",         32'h2, 32'h2, 32'h2, 2'd2, 1'b1, 1'b1);
    apply("R1 enable clear",         32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 1'b1, 1'b1);
    apply("R1 pending clear",        32'h0, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b1, 1'b1);
    apply("R1 top bit",              32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 2'd0, 1'b0, 1'b0);
    apply("R7 upper half",           32'hFFFF_0000, 32'hFFFF_0000, 32'h0, 2'd0, 1'b0, 1'b0);
    apply("R7 deleg masked low",     32'hFF, 32'hFF, 32'hF, 2'd1, 1'b0, 1'b0);
    apply("R7 bit zero",             32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'd1, 1'b0, 1'b0);
    apply("R8 all zero",             32'h0, 32'h0, 32'h0, 2'd3, 1'b1, 1'b1);

    for (int k = 0; k < 400; k++) begin
      seed = next_rand(seed); rp = seed;
      seed = next_rand(seed); re = seed | next_rand(seed);
      seed = next_rand(seed); rd = seed;
      seed = next_rand(seed);
      apply("R7 random", rp, re, rd, seed[1:0], seed[2], seed[3]);
    end

    // R9: reset asserted mid-run clears the outputs at the next edge
    pend = 32'h4; en = 32'h4; dlg = '0; pr = 2'd0;
    @(posedge clk);
    @(negedge clk);
    compare("R9 before reset", 1'b1, 2);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R9 mid reset", 1'b0, 0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

endmodule